// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block watches an asynchronous parallel memory bus (active-low chip enable, active-low write enable, active-low output enable and a 15-bit address) and recognises a fixed series of six reads that software uses to ask for a nonvolatile save or restore. Each low pulse of chip enable is one access. The bus pins are brought into the clock domain through a synchronizer chain, and the access is judged when chip enable returns high, so a write enable that falls anywhere inside the pulse marks the access as a write.

The first five reads form a fixed prefix. The sixth address decides the outcome: one value yields a one-cycle save command, another yields a one-cycle restore command, and every other value, including one pattern kept back for factory use, only clears the match. Any write or any out-of-order read breaks the series. While the downstream save/restore engine reports busy, the detector stays at its start state and discards accesses.

Top module: `seqcmd_detect`

## Requirements
- R1: After reset both command outputs are low and the detector is at its start state.
- R2: Six read pulses at addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0 (bits 13..0) produce exactly one high cycle on store_o.
- R3: The same five-address prefix followed by a read of 0x0C63 produces exactly one high cycle on recall_o.
- R4: Each command lasts one clock cycle, and store_o and recall_o are never high together.
- R5: A sixth read of 0x339C issues no command and clears the match, so a following series missing its first address issues nothing.
- R6: An access during which write enable (active low) is low while chip enable is low aborts the series; no command follows the remaining reads.
- R7: A read at an address other than the expected one aborts the series.
- R8: Output enable has no influence: the series issues its command with oe_ni held high throughout.
- R9: An extra chip-enable low pulse (repeated read of the same address) counts as an access and breaks the series.
- R10: Only address bits 13..0 are compared; bit 14 set on every read still issues the command.
- R11: A mismatching read whose address is 0x0E38 restarts matching at the second step, so the next five correct reads issue the command.
- R12: While busy_i is high no command is issued, accesses are ignored, and the match returns to the start state; a full series after busy falls is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Detector clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Bus chip enable, active low, asynchronous |
| we_ni | input | 1 | Bus write enable, active low, asynchronous |
| oe_ni | input | 1 | Bus output enable, active low, unused for detection |
| addr_i | input | 15 | Bus address |
| busy_i | input | 1 | Save/restore engine busy, synchronous to clk_i |
| store_o | output | 1 | One-cycle save command |
| recall_o | output | 1 | One-cycle restore command |

## Verification
The hardest case to reach is a write or a second enable pulse that arrives inside an otherwise perfect series, since it must be judged as an access in its own right rather than a glitch filtered by the synchronizer. The bench drives write enable low only in the middle of a chip-enable pulse, and issues a duplicate pulse at an already matched address, then finishes the series with correct reads and expects silence. The busy case is reached by raising busy_i halfway through a series and again across a complete one.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;
  localparam int KEY_W   = 14;
  localparam int KEY_LEN = 6;
  localparam int STEP_W  = $clog2(KEY_LEN);

  localparam logic [KEY_W-1:0] STORE_KEY  = 14'h0FC0;
  localparam logic [KEY_W-1:0] RECALL_KEY = 14'h0C63;

  function automatic logic [KEY_W-1:0] prefix_key(input int idx);
    case (idx)
      0:       prefix_key = 14'h0E38;
      1:       prefix_key = 14'h31C7;
      2:       prefix_key = 14'h03E0;
      3:       prefix_key = 14'h3C1F;
      default: prefix_key = 14'h303F;
    endcase
  endfunction
endpackage

// File: rtl/seqcmd_sync.sv
module seqcmd_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[s] <= RST_VAL;
          else         chain_q[s] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[s] <= RST_VAL;
          else         chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/seqcmd_access.sv
// Turns each synchronized chip-enable low pulse into one access event at pulse end.
module seqcmd_access
  import seqcmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_n_i,
  input  logic             we_n_i,
  input  logic [KEY_W-1:0] addr_i,
  input  logic             busy_i,
  output logic             evt_o,
  output logic             evt_wr_o,
  output logic [KEY_W-1:0] evt_addr_o
);
  logic             ce_prev_q;
  logic             live_q;
  logic             wr_q;
  logic [KEY_W-1:0] addr_q;
  logic             fall, rise;

  assign fall = ce_prev_q & ~ce_n_i;
  assign rise = ~ce_prev_q & ce_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_prev_q  <= 1'b1;
      live_q     <= 1'b0;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      evt_o      <= 1'b0;
      evt_wr_o   <= 1'b0;
      evt_addr_o <= '0;
    end else begin
      ce_prev_q <= ce_n_i;
      evt_o     <= 1'b0;
      if (busy_i) begin
        live_q <= 1'b0;
      end else if (fall) begin
        live_q <= 1'b1;
        addr_q <= addr_i;
        wr_q   <= ~we_n_i;
      end else if (rise) begin
        live_q     <= 1'b0;
        evt_o      <= live_q;
        evt_wr_o   <= wr_q | ~we_n_i;
        evt_addr_o <= addr_q;
      end else if (!ce_n_i) begin
        wr_q <= wr_q | ~we_n_i;
      end
    end
  end

  AST_NO_EVT_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !evt_o); // R12
endmodule

// File: rtl/seqcmd_match.sv
module seqcmd_match
  import seqcmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             evt_wr_i,
  input  logic [KEY_W-1:0] evt_addr_i,
  input  logic             busy_i,
  output logic             store_o,
  output logic             recall_o
);
  localparam int LAST = KEY_LEN - 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(LAST);

  logic [STEP_W-1:0] step_q, step_d;
  logic [LAST-1:0]   hit;
  logic              store_d, recall_d;

  generate
    for (genvar i = 0; i < LAST; i++) begin : g_cmp
      assign hit[i] = (evt_addr_i == prefix_key(i));
    end
  endgenerate

  always_comb begin
    step_d   = step_q;
    store_d  = 1'b0;
    recall_d = 1'b0;
    if (busy_i) begin
      step_d = '0;
    end else if (evt_i) begin
      if (evt_wr_i) begin
        step_d = '0;
      end else if (step_q == LAST_STEP) begin
        if (evt_addr_i == STORE_KEY) begin
          store_d = 1'b1;
          step_d  = '0;
        end else if (evt_addr_i == RECALL_KEY) begin
          recall_d = 1'b1;
          step_d   = '0;
        end else begin
          step_d = hit[0] ? STEP_W'(1) : '0;
        end
      end else if (hit[step_q]) begin
        step_d = step_q + STEP_W'(1);
      end else begin
        step_d = hit[0] ? STEP_W'(1) : '0;  // restart on first key
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      store_o  <= 1'b0;
      recall_o <= 1'b0;
    end else begin
      step_q   <= step_d;
      store_o  <= store_d;
      recall_o <= recall_d;
    end
  end

  AST_STEP_RANGE:   assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= LAST_STEP); // R7
  AST_STORE_FULL:   assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> $past(step_q) == LAST_STEP); // R2
  AST_RECALL_FULL:  assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_o |-> $past(step_q) == LAST_STEP); // R3
  AST_BUSY_QUIET:   assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (!store_o && !recall_o && step_q == '0)); // R12
endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic              store_o,
  output logic              recall_o
);
  localparam int SW = KEY_W + 2;

  logic [SW-1:0]    bus_s;
  logic             evt, evt_wr;
  logic [KEY_W-1:0] evt_addr;

  seqcmd_sync #(
    .W(SW), .STAGES(SYNC_STAGES), .RST_VAL({2'b11, {KEY_W{1'b0}}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_ni, we_ni, addr_i[KEY_W-1:0]}),
    .q_o   (bus_s)
  );

  seqcmd_access u_access (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_n_i    (bus_s[SW-1]),
    .we_n_i    (bus_s[SW-2]),
    .addr_i    (bus_s[KEY_W-1:0]),
    .busy_i    (busy_i),
    .evt_o     (evt),
    .evt_wr_o  (evt_wr),
    .evt_addr_o(evt_addr)
  );

  seqcmd_match u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .evt_wr_i  (evt_wr),
    .evt_addr_i(evt_addr),
    .busy_i    (busy_i),
    .store_o   (store_o),
    .recall_o  (recall_o)
  );

  AST_ONE_CMD:     assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_o && recall_o)); // R4
  AST_STORE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |=> !store_o); // R4
  AST_RECALL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_o |=> !recall_o); // R4
  AST_BUS_KNOWN:   assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({oe_ni, addr_i[ADDR_W-1:KEY_W]})); // R8
endmodule

// File: tb/seqcmd_detect_test.sv
`timescale 1ns/1ps
module seqcmd_detect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0, busy = 1'b0;
  logic [14:0] addr = '0;
  logic        store, recall;

  int n_chk = 0, n_bad = 0;
  int n_store = 0, n_recall = 0;
  int run_s = 0, run_r = 0, max_run = 0;
  bit both = 0;

  always #2.5 clk = ~clk;

  seqcmd_detect uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .busy_i(busy), .store_o(store), .recall_o(recall)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (store)  n_store++;
      if (recall) n_recall++;
      if (store && recall) both = 1;
      run_s = store ? run_s + 1 : 0;
      run_r = recall ? run_r + 1 : 0;
      if (run_s > max_run) max_run = run_s;
      if (run_r > max_run) max_run = run_r;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one chip-enable pulse; mid_wr pulls write enable low inside the pulse
  task automatic access(input logic [14:0] a, input bit mid_wr);
    @(negedge clk); addr = a; we_n = 1'b1;
    idle(2);
    ce_n = 1'b0;
    idle(2);
    if (mid_wr) we_n = 1'b0;
    idle(2);
    we_n = 1'b1;
    idle(1);
    ce_n = 1'b1;
    idle(3);
  endtask

  task automatic prefix(input int from, input logic [14:0] hi);
    logic [13:0] k [5];
    k[0] = 14'h0E38; k[1] = 14'h31C7; k[2] = 14'h03E0; k[3] = 14'h3C1F; k[4] = 14'h303F;
    for (int i = from; i < 5; i++) access(hi | {1'b0, k[i]}, 1'b0);
  endtask

  task automatic expect_cmds(input int ds, input int dr, input int s0, input int r0, input string req);
    idle(10);
    chk(n_store - s0 == ds, req, n_store - s0, ds);
    chk(n_recall - r0 == dr, req, n_recall - r0, dr);
  endtask

  task automatic t_reset;
    chk(store == 1'b0, "R1", store, 0);
    chk(recall == 1'b0, "R1", recall, 0);
  endtask

  task automatic t_store;
    int s0 = n_store, r0 = n_recall;
    prefix(0, 15'h0); access(15'h0FC0, 1'b0);
    expect_cmds(1, 0, s0, r0, "R2");
  endtask

  task automatic t_recall;
    int s0 = n_store, r0 = n_recall;
    prefix(0, 15'h0); access(15'h0C63, 1'b0);
    expect_cmds(0, 1, s0, r0, "R3");
  endtask

  task automatic t_reserved;
    int s0 = n_store, r0 = n_recall;
    prefix(0, 15'h0); access(15'h339C, 1'b0);
    expect_cmds(0, 0, s0, r0, "R5");
    s0 = n_store; r0 = n_recall;
    prefix(1, 15'h0); access(15'h0FC0, 1'b0);
    expect_cmds(0, 0, s0, r0, "R5 cleared");
  endtask

  task automatic t_write_abort;
    int s0 = n_store, r0 = n_recall;
    access(15'h0E38, 1'b0); access(15'h31C7, 1'b0);
    access(15'h03E0, 1'b1);
    access(15'h3C1F, 1'b0); access(15'h303F, 1'b0); access(15'h0FC0, 1'b0);
    expect_cmds(0, 0, s0, r0, "R6");
  endtask

  task automatic t_wrong_addr;
    int s0 = n_store, r0 = n_recall;
    access(15'h0E38, 1'b0); access(15'h31C7, 1'b0); access(15'h0123, 1'b0);
    prefix(2, 15'h0); access(15'h0C63, 1'b0);
    expect_cmds(0, 0, s0, r0, "R7");
  endtask

  task automatic t_oe_high;
    int s0 = n_store, r0 = n_recall;
    oe_n = 1'b1;
    prefix(0, 15'h0); access(15'h0FC0, 1'b0);
    oe_n = 1'b0;
    expect_cmds(1, 0, s0, r0, "R8");
  endtask

  task automatic t_glitch;
    int s0 = n_store, r0 = n_recall;
    access(15'h0E38, 1'b0); access(15'h31C7, 1'b0); access(15'h31C7, 1'b0);
    prefix(2, 15'h0); access(15'h0FC0, 1'b0);
    expect_cmds(0, 0, s0, r0, "R9");
  endtask

  task automatic t_bit14;
    int s0 = n_store, r0 = n_recall;
    prefix(0, 15'h4000); access(15'h4C63, 1'b0);
    expect_cmds(0, 1, s0, r0, "R10");
  endtask

  task automatic t_restart;
    int s0 = n_store, r0 = n_recall;
    access(15'h0E38, 1'b0); access(15'h31C7, 1'b0);
    prefix(0, 15'h0); access(15'h0FC0, 1'b0);
    expect_cmds(1, 0, s0, r0, "R11");
  endtask

  task automatic t_busy;
    int s0 = n_store, r0 = n_recall;
    access(15'h0E38, 1'b0); access(15'h31C7, 1'b0); access(15'h03E0, 1'b0);
    @(negedge clk); busy = 1'b1; idle(4); busy = 1'b0;
    access(15'h3C1F, 1'b0); access(15'h303F, 1'b0); access(15'h0FC0, 1'b0);
    expect_cmds(0, 0, s0, r0, "R12 reset by busy");
    s0 = n_store; r0 = n_recall;
    @(negedge clk); busy = 1'b1;
    prefix(0, 15'h0); access(15'h0FC0, 1'b0);
    expect_cmds(0, 0, s0, r0, "R12 ignored while busy");
    busy = 1'b0;
    s0 = n_store; r0 = n_recall;
    prefix(0, 15'h0); access(15'h0C63, 1'b0);
    expect_cmds(0, 1, s0, r0, "R12 after busy");
  endtask

  initial begin
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(3);
    t_reset;
    t_store;
    t_recall;
    t_reserved;
    t_write_abort;
    t_wrong_addr;
    t_oe_high;
    t_glitch;
    t_bit14;
    t_restart;
    t_busy;
    chk(max_run == 1, "R4 width", max_run, 1);
    chk(both == 0, "R4 exclusive", both, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule